// File: doc/BRIEF.md
# Read-Ahead Prefetch Buffer

This block stands between the bus masters and the SDRAM back end and serves master reads from a one-line buffer. The line is 16 bytes, or four doublewords. When a read is not fully resident, the block fetches it from memory. For eligible reads it then fetches the following line on its own, ahead of any request for it. When a later sequential read finds its doublewords in the buffer, it completes in the same cycle it is presented, with no wait states.

Reading ahead depends on who is reading and how much. Only bursts of two or more doublewords from a master other than the DMA engine trigger a prefetch, and only while the enable input is high. A DMA read never prefetches. Instead, its miss fetch always covers the rest of the current line, from the requested doubleword to the line's end.

Writes from any master are watched. A write into the buffered line, or into a line whose fetch is still in flight, keeps stale data from being served. When a demand read misses while a prefetch is still outstanding, the prefetch is abandoned in favour of the demand.

Top module: `readahead_buf`

## Requirements
- R1: After reset there is no memory request and no read completion, and the buffer is empty, so the first read misses.
- R2: A non-DMA read that misses issues a memory request on the next cycle. The request carries the read's doubleword address and its burst length. The read completes in the cycle `memAck` is high and returns `memData`, with doubleword w in bits [32w+31:32w].
- R3: A DMA read (`rdMaster` = 2) that misses requests every doubleword from the requested one to the end of the line, giving a length of 4 minus `rdAddr[1:0]`. The whole remainder is then resident for later hits.
- R4: When a non-DMA read of two or more doublewords completes with the enable high, a request appears on the next cycle. It carries the next line's first doubleword address and a length of 4.
- R5: A read of a single doubleword never starts a prefetch.
- R6: A read from the DMA master never starts a prefetch.
- R7: While `raEnable` is low, no prefetch is started.
- R8: A read whose doublewords are all resident completes in the same cycle it is presented and returns the buffered data.
- R9: The next-line address wraps from the top line of the address space to line 0.
- R10: A write to the buffered line invalidates it, so the next read of that line misses.
- R11: A write to a line whose prefetch is in flight stops that data from being kept, so a later read of that line misses.
- R12: A demand miss seen while a prefetch is outstanding replaces it. On the next cycle the memory request carries the demand read's address.
- R13: A resident read that is otherwise eligible also starts the next-line prefetch on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| raEnable | input | 1 | Read-ahead enable |
| rdValid | input | 1 | Read request, held with its fields until `rdDone` |
| rdAddr | input | 30 | Read doubleword address |
| rdLen | input | 3 | Burst length in doublewords, 1..4, not crossing the line |
| rdMaster | input | 2 | Requesting master; 2 is the DMA engine |
| rdDone | output | 1 | Read completes this cycle |
| rdData | output | 128 | Line data, doubleword w in bits [32w+31:32w] |
| wrValid | input | 1 | A write is happening this cycle |
| wrLine | input | 28 | Line address of that write |
| memReq | output | 1 | Memory fetch outstanding |
| memAddr | output | 30 | First doubleword address of the fetch |
| memLen | output | 3 | Doublewords fetched |
| memAck | input | 1 | Fetch data valid this cycle |
| memData | input | 128 | Fetched line, same layout as `rdData` |

## Verification
Random reads over a handful of neighbouring lines mix burst lengths, word offsets, masters and enable settings. This sorts the four prefetch conditions apart, because each condition alone must suppress the next-cycle request. Repeated lines turn misses into hits and separate partial residency from full residency. DMA reads at nonzero offsets distinguish remainder fetches from burst-length fetches. Directed cases place a write and a second miss inside an outstanding prefetch and read from the top line, so the bench can tell cancellation, stale-fill suppression and address wrap from the ordinary flow.

// File: rtl/readahead_buf_pkg.sv
`timescale 1ns/1ps
package readahead_buf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEMAND,
    ST_PREFETCH
  } rab_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDemand;    // latch a demand fetch from the read port
    logic loadPrefetch;  // latch a next-line fetch
    logic fill;          // memory data arrives for the latched fetch
    logic respFromMem;   // read data comes straight from memory
  } rab_strobe_t;

endpackage

// File: rtl/readahead_buf_dp.sv
`timescale 1ns/1ps
module readahead_buf_dp
  import readahead_buf_pkg::*;
#(
  parameter int DWA_W  = 30,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int MID_W  = 2,
  parameter int DMA_ID = 2,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int LEN_W  = IDX_W + 1,
  localparam int LINE_W = DWA_W - IDX_W,
  localparam int DATA_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              raEnable,
  input  logic [DWA_W-1:0]  rdAddr,
  input  logic [LEN_W-1:0]  rdLen,
  input  logic [MID_W-1:0]  rdMaster,
  input  logic              wrValid,
  input  logic [LINE_W-1:0] wrLine,
  input  logic [DATA_W-1:0] memData,
  input  rab_strobe_t       strobe,
  output logic              hit,
  output logic              eligible,
  output logic [DATA_W-1:0] rdData,
  output logic [DWA_W-1:0]  memAddr,
  output logic [LEN_W-1:0]  memLen
);

  function automatic logic [WORDS-1:0] spanMask(input logic [IDX_W-1:0] idx,
                                                input logic [LEN_W-1:0] len);
    logic [WORDS-1:0] m;
    m = '0;
    for (int w = 0; w < WORDS; w++)
      m[w] = (w >= int'(idx)) && (w < int'(idx) + int'(len));
    return m;
  endfunction

  // buffered line
  logic [LINE_W-1:0] bufTag;
  logic [WORDS-1:0]  bufMask;
  logic [DATA_W-1:0] bufData;

  // fetch in flight
  logic [DWA_W-1:0]  reqDw;
  logic [LEN_W-1:0]  reqLen;
  logic              reqStale;

  logic [LINE_W-1:0] rdLineAddr, nextLine, reqLine;
  logic [IDX_W-1:0]  rdIdx, reqIdx;
  logic [WORDS-1:0]  needMask, reqMask;
  logic [LEN_W-1:0]  remLen;
  logic              isDma, wrHitsReq, wrHitsBuf, fillOk;

  assign rdLineAddr = rdAddr[DWA_W-1:IDX_W];
  assign rdIdx      = rdAddr[IDX_W-1:0];
  assign reqLine    = reqDw[DWA_W-1:IDX_W];
  assign reqIdx     = reqDw[IDX_W-1:0];
  assign nextLine   = rdLineAddr + 1'b1;
  assign needMask   = spanMask(rdIdx, rdLen);
  assign reqMask    = spanMask(reqIdx, reqLen);
  assign remLen     = LEN_W'(WORDS - int'(rdIdx));
  assign isDma      = (rdMaster == MID_W'(DMA_ID));

  assign hit      = (bufTag == rdLineAddr) && ((needMask & ~bufMask) == '0)
                    && (rdLen != '0);
  assign eligible = raEnable && (rdLen >= LEN_W'(2)) && !isDma;

  assign wrHitsReq = wrValid && (wrLine == reqLine);
  assign wrHitsBuf = wrValid && (wrLine == bufTag);
  assign fillOk    = strobe.fill && !reqStale && !wrHitsReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqDw    <= '0;
      reqLen   <= '0;
      reqStale <= 1'b0;
    end else if (strobe.loadDemand) begin
      reqDw    <= rdAddr;
      reqLen   <= isDma ? remLen : rdLen;
      reqStale <= wrValid && (wrLine == rdLineAddr);
    end else if (strobe.loadPrefetch) begin
      reqDw    <= {nextLine, {IDX_W{1'b0}}};
      reqLen   <= LEN_W'(WORDS);
      reqStale <= wrValid && (wrLine == nextLine);
    end else if (wrHitsReq) begin
      reqStale <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufTag  <= '0;
      bufMask <= '0;
      bufData <= '0;
    end else if (fillOk) begin
      bufTag  <= reqLine;
      bufMask <= reqMask;
      bufData <= memData;
    end else if (wrHitsBuf) begin
      bufMask <= '0;
    end
  end

  assign memAddr = reqDw;
  assign memLen  = reqLen;
  assign rdData  = strobe.respFromMem ? memData : bufData;

endmodule

// File: rtl/readahead_buf_ctrl.sv
`timescale 1ns/1ps
module readahead_buf_ctrl
  import readahead_buf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdValid,
  input  logic        hit,
  input  logic        eligible,
  input  logic        memAck,
  output rab_strobe_t strobe,
  output logic        memReq,
  output logic        rdDone
);

  rab_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    rdDone    = 1'b0;
    memReq    = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (rdValid) begin
          if (hit) begin
            rdDone = 1'b1;
            if (eligible) begin
              strobe.loadPrefetch = 1'b1;
              stateNext           = ST_PREFETCH;
            end
          end else begin
            strobe.loadDemand = 1'b1;
            stateNext         = ST_DEMAND;
          end
        end
      end
      ST_PREFETCH: begin
        if (rdValid && hit) rdDone = 1'b1;
        if (memAck) begin
          strobe.fill = 1'b1;
          stateNext   = ST_IDLE;
        end else if (rdValid && !hit) begin
          strobe.loadDemand = 1'b1;
          stateNext         = ST_DEMAND;
        end
      end
      ST_DEMAND: begin
        if (memAck) begin
          strobe.fill        = 1'b1;
          strobe.respFromMem = 1'b1;
          rdDone             = 1'b1;
          if (eligible) begin
            strobe.loadPrefetch = 1'b1;
            stateNext           = ST_PREFETCH;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/readahead_buf.sv
`timescale 1ns/1ps
module readahead_buf
  import readahead_buf_pkg::*;
#(
  parameter int DWA_W  = 30,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int MID_W  = 2,
  parameter int DMA_ID = 2,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int LEN_W  = IDX_W + 1,
  localparam int LINE_W = DWA_W - IDX_W,
  localparam int DATA_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              raEnable,
  input  logic              rdValid,
  input  logic [DWA_W-1:0]  rdAddr,
  input  logic [LEN_W-1:0]  rdLen,
  input  logic [MID_W-1:0]  rdMaster,
  output logic              rdDone,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrValid,
  input  logic [LINE_W-1:0] wrLine,
  output logic              memReq,
  output logic [DWA_W-1:0]  memAddr,
  output logic [LEN_W-1:0]  memLen,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData
);

  rab_strobe_t strobe;
  logic        hit, eligible;

  readahead_buf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdValid  (rdValid),
    .hit      (hit),
    .eligible (eligible),
    .memAck   (memAck),
    .strobe   (strobe),
    .memReq   (memReq),
    .rdDone   (rdDone)
  );

  readahead_buf_dp #(
    .DWA_W  (DWA_W),
    .WORDS  (WORDS),
    .WORD_W (WORD_W),
    .MID_W  (MID_W),
    .DMA_ID (DMA_ID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .raEnable (raEnable),
    .rdAddr   (rdAddr),
    .rdLen    (rdLen),
    .rdMaster (rdMaster),
    .wrValid  (wrValid),
    .wrLine   (wrLine),
    .memData  (memData),
    .strobe   (strobe),
    .hit      (hit),
    .eligible (eligible),
    .rdData   (rdData),
    .memAddr  (memAddr),
    .memLen   (memLen)
  );

endmodule

// File: rtl/readahead_buf_chk.sv
`timescale 1ns/1ps
module readahead_buf_chk #(
  parameter int DWA_W  = 30,
  parameter int WORDS  = 4,
  parameter int MID_W  = 2,
  parameter int DMA_ID = 2,
  localparam int IDX_W = $clog2(WORDS),
  localparam int LEN_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             raEnable,
  input logic             rdValid,
  input logic [DWA_W-1:0] rdAddr,
  input logic [LEN_W-1:0] rdLen,
  input logic [MID_W-1:0] rdMaster,
  input logic             rdDone,
  input logic             memReq,
  input logic [DWA_W-1:0] memAddr,
  input logic [LEN_W-1:0] memLen,
  input logic             memAck
);

  logic isDma, sameLine, canPf, rdEnd;
  assign isDma    = (rdMaster == MID_W'(DMA_ID));
  assign sameLine = (memAddr[DWA_W-1:IDX_W] == rdAddr[DWA_W-1:IDX_W]);
  assign canPf    = raEnable && (rdLen >= LEN_W'(2)) && !isDma;
  assign rdEnd    = rdDone && (memAck || !memReq);

  // R8: completion only answers a presented read
  assert_done_has_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> rdValid);

  // R2: a fetch only starts in response to a read
  assert_fetch_after_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(rdValid));

  assert_dma_remainder_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone && memAck && sameLine && isDma)
      |-> memLen == LEN_W'(WORDS - int'(rdAddr[IDX_W-1:0])));

  assert_next_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone && memAck && sameLine && canPf)
      |=> memReq && memLen == LEN_W'(WORDS)
          && memAddr[IDX_W-1:0] == '0
          && memAddr[DWA_W-1:IDX_W] == $past(rdAddr[DWA_W-1:IDX_W]) + 1'b1);

  assert_short_no_pf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnd && rdLen < LEN_W'(2)) |=> !memReq);

  assert_dma_no_pf_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnd && isDma) |=> !memReq);

  assert_off_no_pf_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnd && !raEnable) |=> !memReq);

  assert_miss_takes_port_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdDone && memReq && !memAck) |=> memReq && memAddr == $past(rdAddr));

endmodule

bind readahead_buf readahead_buf_chk #(
  .DWA_W  (DWA_W),
  .WORDS  (WORDS),
  .MID_W  (MID_W),
  .DMA_ID (DMA_ID)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .raEnable (raEnable),
  .rdValid  (rdValid),
  .rdAddr   (rdAddr),
  .rdLen    (rdLen),
  .rdMaster (rdMaster),
  .rdDone   (rdDone),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memLen   (memLen),
  .memAck   (memAck)
);

// File: tb/readahead_buf_bench.sv
`timescale 1ns/1ps
module readahead_buf_bench;
  localparam int LAT = 3;
  localparam int DMA = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         raEnable = 1'b0, rdValid = 1'b0, wrValid = 1'b0, memAck = 1'b0;
  logic [29:0]  rdAddr = '0;
  logic [2:0]   rdLen = 3'd1;
  logic [1:0]   rdMaster = '0;
  logic [27:0]  wrLine = '0;
  logic [127:0] memData = '0;
  logic         rdDone, memReq;
  logic [127:0] rdData;
  logic [29:0]  memAddr;
  logic [2:0]   memLen;

  always #2 clk = ~clk;

  readahead_buf u_readahead_buf (
    .clk(clk), .rstN(rstN), .raEnable(raEnable), .rdValid(rdValid),
    .rdAddr(rdAddr), .rdLen(rdLen), .rdMaster(rdMaster), .rdDone(rdDone),
    .rdData(rdData), .wrValid(wrValid), .wrLine(wrLine), .memReq(memReq),
    .memAddr(memAddr), .memLen(memLen), .memAck(memAck), .memData(memData)
  );

  int total = 0, bad = 0;
  logic [27:0] mTag = '0;
  logic [3:0]  mMask = '0;
  bit          lastHit;

  function automatic logic [31:0] patt(input logic [29:0] d);
    return ({2'b00, d} * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [3:0] span(input int idx, input int len);
    logic [3:0] m = '0;
    for (int w = 0; w < 4; w++) m[w] = (w >= idx) && (w < idx + len);
    return m;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory back end: fixed latency, restarts when the request changes
  logic [29:0] lastAddr = '0;
  logic [2:0]  lastLen = '0;
  logic        lastReq = 1'b0;
  int          cnt = 0;
  always @(negedge clk) begin
    if (!rstN || !memReq) begin
      cnt = 0;
      memAck = 1'b0;
    end else begin
      if (lastReq && memAddr == lastAddr && memLen == lastLen) cnt++;
      else cnt = 1;
      for (int w = 0; w < 4; w++) memData[w*32 +: 32] = patt({memAddr[29:2], 2'(w)});
      if (cnt == LAT) begin
        memAck = 1'b1;
        cnt = 0;
      end else memAck = 1'b0;
    end
    lastReq = memReq; lastAddr = memAddr; lastLen = memLen;
  end

  task automatic waitIdle();
    for (int n = 0; n < 40 && memReq; n++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic doWrite(input logic [31:0] a);
    @(negedge clk);
    wrValid = 1'b1; wrLine = a[31:4];
    @(negedge clk);
    wrValid = 1'b0;
    if (a[31:4] == mTag) mMask = '0;
  endtask

  task automatic doRead(input logic [31:0] a, input int len, input int mst,
                        input bit en, input bit waitPf);
    int cyc, idx, expLen;
    bit expHit, elig;
    logic [27:0] line, nl;
    logic [127:0] got;
    bit dataOk;
    string tagMiss, tagPf;
    line = a[31:4]; idx = int'(a[3:2]); nl = line + 28'd1;
    expHit = (mTag == line) && ((span(idx, len) & ~mMask) == 4'h0);
    elig = en && len >= 2 && mst != DMA;
    expLen = (mst == DMA) ? 4 - idx : len;
    tagMiss = (mst == DMA) ? "R3" : "R2";
    @(negedge clk);
    raEnable = en; rdValid = 1'b1; rdAddr = a[31:2];
    rdLen = 3'(len); rdMaster = 2'(mst);
    #1;
    cyc = 0;
    while (!rdDone && cyc < 40) begin
      @(negedge clk); #1;
      cyc++;
      if (cyc == 1)
        check(!expHit && memReq && memAddr == a[31:2] && memLen == 3'(expLen),
              tagMiss, {memReq, memAddr, memLen}, {1'b1, a[31:2], 3'(expLen)});
    end
    lastHit = (cyc == 0);
    if (expHit) check(cyc == 0, "R8", cyc, 0);
    else        check(cyc == LAT, tagMiss, cyc, LAT);
    got = rdData;
    dataOk = 1'b1;
    for (int w = idx; w < idx + len; w++)
      if (got[w*32 +: 32] != patt({line, 2'(w)})) dataOk = 1'b0;
    check(dataOk, expHit ? "R8" : "R2", got[63:0], {patt({line, 2'(idx + 1)}), patt({line, 2'(idx)})});
    if (!expHit) begin
      mTag = line;
      mMask = (mst == DMA) ? span(idx, 4 - idx) : span(idx, len);
    end
    @(negedge clk);
    rdValid = 1'b0;
    #1;
    if (!en) tagPf = "R7";
    else if (mst == DMA) tagPf = "R6";
    else if (len < 2) tagPf = "R5";
    else if (expHit) tagPf = "R13";
    else tagPf = "R4";
    check(memReq == elig, tagPf, memReq, elig);
    if (elig)
      check(memAddr == {nl, 2'b00} && memLen == 3'd4, (line == '1) ? "R9" : tagPf,
            {memAddr, memLen}, {nl, 2'b00, 3'd4});
    if (waitPf) begin
      waitIdle();
      if (elig) begin
        mTag = nl;
        mMask = 4'hF;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4099));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!memReq && !rdDone, "R1", {memReq, rdDone}, 0);

    // R1 first read misses; R4 eligible miss prefetches the next line
    doRead(32'h0000_0100, 2, 0, 1, 1);
    check(!lastHit, "R1", lastHit, 0);
    // R13 hit on prefetched line launches the following line
    doRead(32'h0000_0110, 2, 1, 1, 1);
    check(lastHit, "R13", lastHit, 1);
    // R10 write to buffered line invalidates it
    doWrite(32'h0000_0124);
    doRead(32'h0000_0120, 1, 0, 1, 1);
    check(!lastHit, "R10", lastHit, 0);
    // R3 DMA remainder then hit on a later word, R6 no prefetch
    doRead(32'h0000_0208, 1, DMA, 1, 1);
    doRead(32'h0000_020C, 1, 0, 1, 1);
    check(lastHit, "R3", lastHit, 1);
    doRead(32'h0000_0300, 1, 0, 1, 1);          // R5
    doRead(32'h0000_0400, 4, 0, 0, 1);          // R7
    doRead(32'hFFFF_FFF0, 4, 0, 1, 1);          // R9
    doRead(32'h0000_0000, 4, 1, 1, 1);
    check(lastHit, "R9", lastHit, 1);
    // R12 demand miss cancels an outstanding prefetch
    doRead(32'h0000_0500, 2, 0, 1, 0);
    doRead(32'h0000_0700, 1, 0, 1, 1);
    doRead(32'h0000_0510, 1, 0, 1, 1);
    check(!lastHit, "R12", lastHit, 0);
    // R11 write into the line being prefetched
    doRead(32'h0000_0600, 2, 0, 1, 0);
    doWrite(32'h0000_0614);
    waitIdle();
    doRead(32'h0000_0610, 1, 0, 1, 1);
    check(!lastHit, "R11", lastHit, 0);

    for (int i = 0; i < 250; i++) begin
      logic [31:0] a;
      int idx, len;
      a = 32'h0000_0800 + 32'($urandom_range(0, 5)) * 16;
      if ($urandom_range(0, 4) == 0) doWrite(a);
      else begin
        idx = $urandom_range(0, 3);
        len = $urandom_range(1, 4 - idx);
        doRead(a + 32'(idx * 4), len, $urandom_range(0, 2), $urandom_range(0, 3) != 0, 1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule